// File: doc/BRIEF.md
# Multiport Latch Register File

A small register file whose storage bits are level-sensitive latches rather than edge-triggered flip-flops. Several write ports and several read ports reach one shared array of words. Each write request is captured on the rising clock edge. During the low phase that follows, only the latch clocks of the addressed word are opened, so the captured data flows into that word. When the clock rises again, the word closes and holds the data.

Each word has a small merge mux in front of its latches, which chooses which write port's data it captures. When several write ports name the same word in one cycle, the lowest-numbered port supplies the data. Each read port is a purely combinational decode of its address over all words. A parameter mask can give any read port a transparent-low output latch. Such a port then holds its result steady through the high phase while its address moves on. Addresses at or above the word count select no word: writes to them are dropped and reads of them return zero.

The default is 32 words of 32 bits, a 6-bit address, two write ports and two read ports. Read port 1 has the output latch and read port 0 is combinational. The block is meant for small, many-ported state where a compiled array would carry too much periphery.

Top module: `lrf_multiport`

## Requirements
- R1: After `rst` has been high for at least two rising edges and then falls, every word reads zero on every read port.
- R2: A write with its enable bit set, presented before rising edge N, becomes readable on all read ports during the low phase of the cycle that follows edge N. It stays readable until that word is written again.
- R3: A write port whose enable bit is low changes no word, whatever address and data it carries.
- R4: Two write ports that name different words in the same cycle both store their data.
- R5: When two or more enabled write ports name the same word in one cycle, the word takes the data of the lowest-numbered of those ports (port 0 over port 1).
- R6: A write whose address is at or above the word count (32..63 by default) changes no word.
- R7: A read whose address is at or above the word count returns all zeros.
- R8: Each read port returns the word at its own address, independently of the other read ports, including when both name the same word.
- R9: A read port with its bit set in `LATCH_MASK` (bit r for port r; by default port 1 only) passes data while the clock is low. While the clock is high it holds the value from the last low phase, even if its address has changed.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; latches are open while it is low |
| rst | input | 1 | Synchronous active-high reset; clears all words |
| wr_en | input | NWP | Write enable, bit p for write port p |
| wr_addr | input | NWP*AW | Write addresses, port p in bits [p*AW +: AW] |
| wr_data | input | NWP*DW | Write data, port p in bits [p*DW +: DW] |
| rd_addr | input | NRP*AW | Read addresses, port r in bits [r*AW +: AW] |
| rd_data | output | NRP*DW | Read data, port r in bits [r*DW +: DW] |

## Verification
The two functions that can fall in the same cycle are two writes aimed at one word and reads of that word. The bench provokes the collision both directly and in random traffic, where a quarter of the cycles force both write addresses equal while other enables and addresses vary. Each collision is judged by reading the word one cycle later on both read ports. The value must match the lowest-numbered enabled port in a reference model that applies port writes from highest to lowest. In every cycle, the latched read port is also sampled early in the high phase after its address has changed, to confirm that it still holds its previous value.

// File: rtl/lrf_pkg.sv
package lrf_pkg;

    // How a read port presents its data
    typedef enum logic {
        RD_COMB  = 1'b0,
        RD_LATCH = 1'b1
    } rd_style_e;

    // True when an address selects an existing word
    function automatic logic addr_in_range(input logic [31:0] a, input int unsigned n_words);
        return a < n_words;
    endfunction

    // Pick the read style for port r from a bit mask
    function automatic rd_style_e style_of(input int unsigned mask, input int unsigned r);
        return ((mask >> r) & 1) != 0 ? RD_LATCH : RD_COMB;
    endfunction

endpackage

// File: rtl/lrf_wr_stage.sv
module lrf_wr_stage
    import lrf_pkg::*;
#(
    parameter int unsigned WORDS = 32,
    parameter int unsigned DW    = 32,
    parameter int unsigned AW    = 6,
    parameter int unsigned NWP   = 2
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic [NWP-1:0]       wr_en,
    input  logic [NWP*AW-1:0]    wr_addr,
    input  logic [NWP*DW-1:0]    wr_data,
    output logic                 stg_clr,
    output logic [NWP-1:0]       stg_en,
    output logic [AW-1:0]        stg_addr [NWP],
    output logic [DW-1:0]        stg_data [NWP]
);

    // Enables and the clear flag carry reset; address and data do not
    always_ff @(posedge clk) begin
        if (rst) begin
            stg_clr <= 1'b1;
            stg_en  <= '0;
        end else begin
            stg_clr <= 1'b0;
            for (int p = 0; p < NWP; p++) begin
                stg_en[p] <= wr_en[p] && addr_in_range(32'(wr_addr[p*AW +: AW]), WORDS);
            end
        end
    end

    always_ff @(posedge clk) begin
        for (int p = 0; p < NWP; p++) begin
            stg_addr[p] <= wr_addr[p*AW +: AW];
            stg_data[p] <= wr_data[p*DW +: DW];
        end
    end

    for (genvar p = 0; p < NWP; p++) begin : g_chk
        // R6
        oor_write_dropped_chk: assert property (@(posedge clk) disable iff (rst)
            (wr_en[p] && !addr_in_range(32'(wr_addr[p*AW +: AW]), WORDS)) |=> !stg_en[p]);
        // R3
        idle_port_quiet_chk: assert property (@(posedge clk) disable iff (rst)
            !wr_en[p] |=> !stg_en[p]);
    end

endmodule

// File: rtl/lrf_word.sv
module lrf_word #(
    parameter int unsigned DW  = 32,
    parameter int unsigned NWP = 2
) (
    input  logic           clk,
    input  logic           clr,
    input  logic [NWP-1:0] hit,
    input  logic [DW-1:0]  wdata [NWP],
    output logic [DW-1:0]  q
);

    logic [DW-1:0] merged;
    logic [DW-1:0] din;
    logic          gate;

    // Merge mux: scan from the top port down so the lowest hit wins
    always_comb begin
        merged = '0;
        for (int p = NWP - 1; p >= 0; p--) begin
            if (hit[p]) merged = wdata[p];
        end
    end

    assign din  = clr ? '0 : merged;
    assign gate = ~clk & (clr | (|hit));

    // Transparent-low storage latch, opened only for the selected word
    always_latch begin
        if (gate) q <= din;
    end

endmodule

// File: rtl/lrf_rd_port.sv
module lrf_rd_port
    import lrf_pkg::*;
#(
    parameter int unsigned WORDS = 32,
    parameter int unsigned DW    = 32,
    parameter int unsigned AW    = 6,
    parameter rd_style_e   STYLE = RD_COMB
) (
    input  logic          clk,
    input  logic          rst,
    input  logic [AW-1:0] raddr,
    input  logic [DW-1:0] words [WORDS],
    output logic [DW-1:0] rdata
);

    logic [DW-1:0] pick;

    // Decoded mux; no match leaves zero
    always_comb begin
        pick = '0;
        for (int w = 0; w < WORDS; w++) begin
            if (raddr == AW'(w)) pick = words[w];
        end
    end

    if (STYLE == RD_LATCH) begin : g_latched
        always_latch begin
            if (!clk) rdata <= pick;
        end
    end else begin : g_comb
        assign rdata = pick;
    end

    // R7
    oor_read_zero_chk: assert property (@(posedge clk) disable iff (rst)
        !addr_in_range(32'(raddr), WORDS) |-> (rdata == '0));

endmodule

// File: rtl/lrf_multiport.sv
module lrf_multiport
    import lrf_pkg::*;
#(
    parameter int unsigned WORDS      = 32,
    parameter int unsigned DW         = 32,
    parameter int unsigned AW         = 6,
    parameter int unsigned NWP        = 2,
    parameter int unsigned NRP        = 2,
    parameter int unsigned LATCH_MASK = 2
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [NWP-1:0]    wr_en,
    input  logic [NWP*AW-1:0] wr_addr,
    input  logic [NWP*DW-1:0] wr_data,
    input  logic [NRP*AW-1:0] rd_addr,
    output logic [NRP*DW-1:0] rd_data
);

    localparam int unsigned IW = (WORDS > 1) ? $clog2(WORDS) : 1;

    logic              stg_clr;
    logic [NWP-1:0]    stg_en;
    logic [AW-1:0]     stg_addr [NWP];
    logic [DW-1:0]     stg_data [NWP];
    logic [NWP-1:0]    hit [WORDS];
    logic [DW-1:0]     word_q [WORDS];
    logic [NWP-1:0]    shadowed;

    lrf_wr_stage #(.WORDS(WORDS), .DW(DW), .AW(AW), .NWP(NWP)) u_stage (
        .clk      (clk),
        .rst      (rst),
        .wr_en    (wr_en),
        .wr_addr  (wr_addr),
        .wr_data  (wr_data),
        .stg_clr  (stg_clr),
        .stg_en   (stg_en),
        .stg_addr (stg_addr),
        .stg_data (stg_data)
    );

    // Write decode and storage words
    for (genvar w = 0; w < WORDS; w++) begin : g_word
        for (genvar p = 0; p < NWP; p++) begin : g_dec
            assign hit[w][p] = stg_en[p] && (stg_addr[p] == AW'(w));
        end
        lrf_word #(.DW(DW), .NWP(NWP)) u_word (
            .clk   (clk),
            .clr   (stg_clr),
            .hit   (hit[w]),
            .wdata (stg_data),
            .q     (word_q[w])
        );
    end

    // Read ports, style chosen per port by mask
    for (genvar r = 0; r < NRP; r++) begin : g_rd
        lrf_rd_port #(
            .WORDS (WORDS),
            .DW    (DW),
            .AW    (AW),
            .STYLE (style_of(LATCH_MASK, r))
        ) u_rd (
            .clk   (clk),
            .rst   (rst),
            .raddr (rd_addr[r*AW +: AW]),
            .words (word_q),
            .rdata (rd_data[r*DW +: DW])
        );
    end

    // A port is shadowed when a lower enabled port names the same word
    always_comb begin
        shadowed = '0;
        for (int p = 1; p < NWP; p++) begin
            for (int q = 0; q < p; q++) begin
                if (stg_en[q] && stg_en[p] && (stg_addr[q] == stg_addr[p])) shadowed[p] = 1'b1;
            end
        end
    end

    logic all_zero;
    always_comb begin
        all_zero = 1'b1;
        for (int w = 0; w < WORDS; w++) begin
            if (word_q[w] != '0) all_zero = 1'b0;
        end
    end

    // R1
    reset_clears_chk: assert property (@(posedge clk) disable iff (rst)
        $fell(rst) |-> all_zero);

    for (genvar p = 0; p < NWP; p++) begin : g_wchk
        // R2, R4, R5: each unshadowed enabled port lands in its word
        write_lands_chk: assert property (@(posedge clk) disable iff (rst)
            (stg_en[p] && !shadowed[p] && !stg_clr)
            |-> (word_q[stg_addr[p][IW-1:0]] == stg_data[p]));
    end

endmodule

// File: tb/lrf_multiport_bench.sv
`timescale 1ns/100ps
module lrf_multiport_bench;

    localparam int unsigned WORDS = 32;
    localparam int unsigned DW    = 32;
    localparam int unsigned AW    = 6;

    logic           clk = 1'b0;
    logic           rst;
    logic [1:0]     wr_en;
    logic [2*AW-1:0] wr_addr;
    logic [2*DW-1:0] wr_data;
    logic [2*AW-1:0] rd_addr;
    logic [2*DW-1:0] rd_data;

    int unsigned n_checks = 0;
    int unsigned n_fails  = 0;
    bit          done     = 0;

    logic [DW-1:0] model [WORDS];
    logic [DW-1:0] last_p1;
    bit            have_prev = 0;

    always #2.5 clk = ~clk;

    lrf_multiport u_lrf_multiport (
        .clk     (clk),
        .rst     (rst),
        .wr_en   (wr_en),
        .wr_addr (wr_addr),
        .wr_data (wr_data),
        .rd_addr (rd_addr),
        .rd_data (rd_data)
    );

    function automatic logic [DW-1:0] expect_rd(input logic [AW-1:0] a);
        return (a < WORDS) ? model[a[4:0]] : '0;
    endfunction

    task automatic check(input string tag, input logic [DW-1:0] act, input logic [DW-1:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fails++;
            $display("FAIL %s: got %h expected %h at %0t", tag, act, exp, $time);
        end
    endtask

    // One cycle: entered just after a rising edge
    task automatic step(input logic [1:0] en,
                        input logic [AW-1:0] a0, input logic [AW-1:0] a1,
                        input logic [DW-1:0] d0, input logic [DW-1:0] d1,
                        input logic [AW-1:0] r0, input logic [AW-1:0] r1,
                        input string tag);
        wr_en   = en;
        wr_addr = {a1, a0};
        wr_data = {d1, d0};
        rd_addr = {r1, r0};
        #0.5;
        // R9: latched port still holds last low-phase value
        if (have_prev) check("R9 hold", rd_data[DW +: DW], last_p1);
        @(negedge clk);
        #1;
        check({tag, " port0"}, rd_data[0 +: DW], expect_rd(r0));
        check({tag, " port1"}, rd_data[DW +: DW], expect_rd(r1));
        last_p1   = rd_data[DW +: DW];
        have_prev = 1;
        @(posedge clk);
        // apply captured writes, high port first so port 0 wins
        if (en[1] && a1 < WORDS) model[a1[4:0]] = d1;
        if (en[0] && a0 < WORDS) model[a0[4:0]] = d0;
        #1;
    endtask

    initial begin
        #1000000;
        if (!done) begin
            n_fails++;
            n_checks++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'h1A7C_5EED));
        rst     = 1'b1;
        wr_en   = '0;
        wr_addr = '0;
        wr_data = '0;
        rd_addr = '0;
        for (int w = 0; w < WORDS; w++) model[w] = '0;
        repeat (3) @(posedge clk);
        #1;
        rst = 1'b0;

        // R1: every word zero after reset
        for (int w = 0; w < WORDS; w += 2)
            step(2'b00, 0, 0, 0, 0, AW'(w), AW'(w + 1), "R1 reset");

        // R2: single write then read on both ports
        step(2'b01, 6'd5, 6'd0, 32'hCAFE_0005, 32'h0, 6'd0, 6'd0, "R2 issue");
        step(2'b00, 0, 0, 0, 0, 6'd5, 6'd5, "R2 readback");

        // R4: two ports, different words
        step(2'b11, 6'd7, 6'd20, 32'h1111_0007, 32'h2222_0014, 6'd5, 6'd0, "R4 issue");
        step(2'b00, 0, 0, 0, 0, 6'd7, 6'd20, "R4 readback");

        // R5: same word, port 0 wins
        step(2'b11, 6'd9, 6'd9, 32'hAAAA_0009, 32'hBBBB_0009, 6'd7, 6'd20, "R5 issue");
        step(2'b00, 0, 0, 0, 0, 6'd9, 6'd9, "R5 lowest port wins");

        // R5: only port 1 enabled on the same address
        step(2'b10, 6'd9, 6'd9, 32'hDEAD_0000, 32'h5555_0009, 6'd9, 6'd0, "R5 issue2");
        step(2'b00, 0, 0, 0, 0, 6'd9, 6'd31, "R5 port1 alone");

        // R3: disabled ports change nothing
        step(2'b00, 6'd5, 6'd7, 32'hFFFF_FFFF, 32'hFFFF_FFFF, 6'd5, 6'd7, "R3 issue");
        step(2'b00, 0, 0, 0, 0, 6'd5, 6'd7, "R3 no change");

        // R6: out-of-range writes dropped, aliased word untouched
        step(2'b11, 6'd37, 6'd52, 32'h0BAD_0025, 32'h0BAD_0034, 6'd5, 6'd20, "R6 issue");
        step(2'b00, 0, 0, 0, 0, 6'd5, 6'd20, "R6 alias untouched");

        // R7: out-of-range reads return zero
        step(2'b00, 0, 0, 0, 0, 6'd37, 6'd63, "R7 oor read");

        // R8: random traffic with forced collisions
        for (int i = 0; i < 1500; i++) begin
            logic [1:0]    en;
            logic [AW-1:0] a0, a1, r0, r1;
            logic [DW-1:0] d0, d1;
            en = 2'($urandom_range(0, 3));
            a0 = AW'($urandom_range(0, 39));
            a1 = ($urandom_range(0, 3) == 0) ? a0 : AW'($urandom_range(0, 39));
            d0 = $urandom;
            d1 = $urandom;
            r0 = AW'($urandom_range(0, 39));
            r1 = ($urandom_range(0, 7) == 0) ? r0 : AW'($urandom_range(0, 39));
            step(en, a0, a1, d0, d1, r0, r1, "R8 random");
        end

        done = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
        $finish;
    end

endmodule